// File: doc/BRIEF.md
# Shared Cache Maintenance Walker

This block is the maintenance engine of a shared second-level cache. Software triggers it by writing small command registers. It then walks a modelled array of per-line valid and dirty bits, either the whole array or only the lines that fall inside an address region. Each dirty line that must be cleaned is sent out as a writeback request under a request/acknowledge handshake. Lines are invalidated or cleaned as the operation requires.

A busy flag in the control register rises on the same clock edge that accepts a triggering write, so software can poll it straight away. The flag stays high until the last line, including its writeback, has been handled. A region operation needs two writes: the end-address write arms it and the start-address write fires it. The line size is set by a configuration pin. A fill port stands in for normal cache traffic so that the line state can be preloaded.

Top module: `l2m_engine`

## Requirements
- R1: After reset the control register reads 0, no line is valid or dirty, busy is low and no writeback is requested.
- R2: The control register (select 0) holds a disable bit at bit 0, a mode bit at bit 6 and a region-operation code at bits 11:9, all writable. Bit 8 (busy) and bit 12 (error) reflect internal state. All other bits read 0. Writing bit 12 as 1 clears the error flag.
- R3: Busy (control bit 8) is set on the clock edge that accepts a launching write, so the next read returns 1. It stays 1 until the edge on which the last line of the operation completes, including the acknowledge of that line's writeback.
- R4: Writing a value with bit 0 set to select 4 flushes the whole cache. Lines are visited in ascending index order. Each valid dirty line raises wb_req with wb_addr = index × line size, and both hold steady until wb_ack. Afterwards every dirty bit is 0 and every valid bit is unchanged.
- R5: Writing a value with bit 0 set to select 3 invalidates the whole cache. With the mode bit at 0 no writeback is issued. With the mode bit at 1 every valid dirty line is written back first. In both cases all lines end up invalid.
- R6: Writing select 2 stores the region end and arms the region. The next write to select 1 consumes the arm and launches over line indices idx(start) through idx(end) inclusive, where idx(a) = (a / line size) mod N_LINES. No launch happens if the region is not armed, if the start value equals the stored end, or if idx(end) < idx(start).
- R7: A region operation takes its type from control bits 11:9. Code 000 is a flush. Code 001 is an invalidate when the mode bit is 0 and a flush-and-invalidate when it is 1. Any other code launches nothing.
- R8: With cfg_lsz = 0 a line is 128 bytes; with cfg_lsz = 1 a line is 64 bytes. This size sets both the region indexing and wb_addr.
- R9: While the disable bit is 1, writes to selects 1 to 4 have no effect: there is no launch, no arm and no change to line state.
- R10: A write to selects 1 to 4 while busy is ignored and sets the sticky error flag (control bit 12).
- R11: A fill (fill_en) while the engine is idle sets the addressed line valid, with its dirty bit taken from fill_dirty. A fill while busy is ignored.
- R12: A visited line that needs no writeback takes exactly one cycle, so a whole-cache operation with no writebacks holds busy for N_LINES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lsz | input | 1 | Line-size configuration: 0 for 128-byte lines, 1 for 64-byte lines |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 control, 1 region start, 2 region end, 3 whole invalidate, 4 whole flush |
| wr_data | input | 32 | Register write data |
| ctrl_rdata | output | 32 | Control register read value |
| fill_en | input | 1 | Model fill strobe |
| fill_idx | input | IDX_W | Line index to fill |
| fill_dirty | input | 1 | Dirty value for the filled line |
| wb_req | output | 1 | Writeback request |
| wb_addr | output | 32 | Address of the line being written back |
| wb_ack | input | 1 | Writeback acknowledge |
| line_valid | output | N_LINES | Valid bit of each line |
| line_dirty | output | N_LINES | Dirty bit of each line |

## Verification
The effects of a register write are due at the clock edge that samples it, so busy, error and control fields are compared at the falling edge one cycle after the write. The walker's effect on a line is due at the edge that retires that line: one cycle after the previous line retires for a clean line, and the acknowledge edge for a dirty one. wb_req and wb_addr are due in the cycle the line becomes current. A behavioural model in the bench holds a queue of pending line indices and advances on every rising edge. All outputs are compared with that model at every falling edge, and directed checks measure the busy duration and the order of writeback addresses.

// File: rtl/l2m_pkg.sv
package l2m_pkg;

  localparam int ADDR_W = 32;

  // register selects
  localparam logic [2:0] SEL_CTRL   = 3'd0;
  localparam logic [2:0] SEL_RSTART = 3'd1;
  localparam logic [2:0] SEL_REND   = 3'd2;
  localparam logic [2:0] SEL_INVALL = 3'd3;
  localparam logic [2:0] SEL_FLALL  = 3'd4;

  // control bit positions
  localparam int CB_DIS  = 0;
  localparam int CB_MODE = 6;
  localparam int CB_BUSY = 8;
  localparam int CB_ROP  = 9;
  localparam int CB_ERR  = 12;

  typedef struct packed {
    logic ok;
    logic wb;
    logic inv;
  } maint_op_t;

  function automatic logic [ADDR_W-1:0] line_number(input logic [ADDR_W-1:0] a,
                                                    input logic lsz);
    return lsz ? (a >> 6) : (a >> 7);
  endfunction

  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] n,
                                                  input logic lsz);
    return lsz ? (n << 6) : (n << 7);
  endfunction

  function automatic maint_op_t region_op(input logic [2:0] code, input logic mode);
    maint_op_t o;
    o = '0;
    if (code == 3'b000) begin
      o.ok = 1'b1; o.wb = 1'b1; o.inv = 1'b0;
    end else if (code == 3'b001) begin
      o.ok = 1'b1; o.wb = mode; o.inv = 1'b1;
    end
    return o;
  endfunction

  function automatic maint_op_t whole_inv_op(input logic mode);
    maint_op_t o;
    o.ok = 1'b1; o.wb = mode; o.inv = 1'b1;
    return o;
  endfunction

  function automatic maint_op_t whole_flush_op();
    maint_op_t o;
    o.ok = 1'b1; o.wb = 1'b1; o.inv = 1'b0;
    return o;
  endfunction

endpackage

// File: rtl/l2m_regs.sv
module l2m_regs
  import l2m_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_lsz,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              busy,
  output logic [31:0]       ctrl_rdata,
  output logic              launch,
  output maint_op_t         launch_op,
  output logic [IDX_W-1:0]  launch_first,
  output logic [IDX_W-1:0]  launch_last,
  output logic              blocked_wr
);

  logic              dis_q, mode_q, err_q, armed_q;
  logic [2:0]        rop_q;
  logic [ADDR_W-1:0] end_q;
  logic              is_trig, accept;
  logic [ADDR_W-1:0] start_line, end_line;
  logic [IDX_W-1:0]  start_idx, end_idx;
  maint_op_t         rgn_op;

  assign is_trig    = wr_en && (wr_sel == SEL_RSTART || wr_sel == SEL_REND ||
                                wr_sel == SEL_INVALL || wr_sel == SEL_FLALL);
  assign blocked_wr = is_trig && busy;
  assign accept     = is_trig && !busy && !dis_q;

  assign start_line = line_number(wr_data, cfg_lsz);
  assign end_line   = line_number(end_q, cfg_lsz);
  assign start_idx  = start_line[IDX_W-1:0];
  assign end_idx    = end_line[IDX_W-1:0];
  assign rgn_op     = region_op(rop_q, mode_q);

  always_comb begin
    launch       = 1'b0;
    launch_op    = '0;
    launch_first = '0;
    launch_last  = '0;
    if (accept) begin
      case (wr_sel)
        SEL_RSTART: begin
          if (armed_q && wr_data != end_q && end_idx >= start_idx && rgn_op.ok) begin
            launch       = 1'b1;
            launch_op    = rgn_op;
            launch_first = start_idx;
            launch_last  = end_idx;
          end
        end
        SEL_INVALL: begin
          if (wr_data[0]) begin
            launch      = 1'b1;
            launch_op   = whole_inv_op(mode_q);
            launch_last = '1;
          end
        end
        SEL_FLALL: begin
          if (wr_data[0]) begin
            launch      = 1'b1;
            launch_op   = whole_flush_op();
            launch_last = '1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dis_q   <= 1'b0;
      mode_q  <= 1'b0;
      rop_q   <= 3'b000;
      err_q   <= 1'b0;
      armed_q <= 1'b0;
      end_q   <= '0;
    end else begin
      if (wr_en && wr_sel == SEL_CTRL) begin
        dis_q  <= wr_data[CB_DIS];
        mode_q <= wr_data[CB_MODE];
        rop_q  <= wr_data[CB_ROP +: 3];
        if (wr_data[CB_ERR]) err_q <= 1'b0;
      end else if (blocked_wr) begin
        err_q <= 1'b1;
      end
      if (accept && wr_sel == SEL_REND) begin
        end_q   <= wr_data;
        armed_q <= 1'b1;
      end
      if (accept && wr_sel == SEL_RSTART) armed_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_rdata                 = '0;
    ctrl_rdata[CB_DIS]         = dis_q;
    ctrl_rdata[CB_MODE]        = mode_q;
    ctrl_rdata[CB_BUSY]        = busy;
    ctrl_rdata[CB_ROP +: 3]    = rop_q;
    ctrl_rdata[CB_ERR]         = err_q;
  end

endmodule

// File: rtl/l2m_walker.sv
module l2m_walker
  import l2m_pkg::*;
#(
  parameter int N_LINES = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_lsz,
  input  logic               launch,
  input  maint_op_t          launch_op,
  input  logic [IDX_W-1:0]   launch_first,
  input  logic [IDX_W-1:0]   launch_last,
  input  logic [N_LINES-1:0] line_valid,
  input  logic [N_LINES-1:0] line_dirty,
  input  logic               wb_ack,
  output logic               busy,
  output logic               wb_req,
  output logic [ADDR_W-1:0]  wb_addr,
  output logic               step,
  output logic               walk_done,
  output logic [IDX_W-1:0]   cur_idx,
  output logic               cur_inv,
  output logic               cur_wb
);

  logic             busy_q, lsz_q;
  logic [IDX_W-1:0] idx_q, last_q;
  maint_op_t        op_q;
  logic             need_wb;

  assign busy      = busy_q;
  assign cur_idx   = idx_q;
  assign cur_inv   = op_q.inv;
  assign cur_wb    = op_q.wb;
  assign need_wb   = op_q.wb && line_valid[idx_q] && line_dirty[idx_q];
  assign wb_req    = busy_q && need_wb;
  assign wb_addr   = line_base({{(ADDR_W-IDX_W){1'b0}}, idx_q}, lsz_q);
  assign step      = busy_q && (!need_wb || wb_ack);
  assign walk_done = step && (idx_q == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lsz_q  <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      op_q   <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      lsz_q  <= cfg_lsz;
      idx_q  <= launch_first;
      last_q <= launch_last;
      op_q   <= launch_op;
    end else if (step) begin
      if (walk_done) busy_q <= 1'b0;
      else           idx_q  <= idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/l2m_lines.sv
module l2m_lines #(
  parameter int N_LINES = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic               fill_dirty,
  input  logic               upd_en,
  input  logic [IDX_W-1:0]   upd_idx,
  input  logic               upd_inv,
  output logic [N_LINES-1:0] line_valid,
  output logic [N_LINES-1:0] line_dirty
);

  logic fill_ok;
  assign fill_ok = fill_en && !busy;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic hit_upd, hit_fill;
    assign hit_upd  = upd_en && (upd_idx == IDX_W'(i));
    assign hit_fill = fill_ok && (fill_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        line_valid[i] <= 1'b0;
        line_dirty[i] <= 1'b0;
      end else if (hit_upd) begin
        line_dirty[i] <= 1'b0;
        if (upd_inv) line_valid[i] <= 1'b0;
      end else if (hit_fill) begin
        line_valid[i] <= 1'b1;
        line_dirty[i] <= fill_dirty;
      end
    end
  end

endmodule

// File: rtl/l2m_engine.sv
module l2m_engine
  import l2m_pkg::*;
#(
  parameter  int N_LINES = 16,
  localparam int IDX_W   = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_lsz,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [31:0]        wr_data,
  output logic [31:0]        ctrl_rdata,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic               fill_dirty,
  output logic               wb_req,
  output logic [31:0]        wb_addr,
  input  logic               wb_ack,
  output logic [N_LINES-1:0] line_valid,
  output logic [N_LINES-1:0] line_dirty
);

  logic             launch, blocked_wr, busy, step, walk_done, cur_inv, cur_wb;
  maint_op_t        launch_op;
  logic [IDX_W-1:0] launch_first, launch_last, cur_idx;

  l2m_regs #(.IDX_W(IDX_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_lsz      (cfg_lsz),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .busy         (busy),
    .ctrl_rdata   (ctrl_rdata),
    .launch       (launch),
    .launch_op    (launch_op),
    .launch_first (launch_first),
    .launch_last  (launch_last),
    .blocked_wr   (blocked_wr)
  );

  l2m_walker #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_lsz      (cfg_lsz),
    .launch       (launch),
    .launch_op    (launch_op),
    .launch_first (launch_first),
    .launch_last  (launch_last),
    .line_valid   (line_valid),
    .line_dirty   (line_dirty),
    .wb_ack       (wb_ack),
    .busy         (busy),
    .wb_req       (wb_req),
    .wb_addr      (wb_addr),
    .step         (step),
    .walk_done    (walk_done),
    .cur_idx      (cur_idx),
    .cur_inv      (cur_inv),
    .cur_wb       (cur_wb)
  );

  l2m_lines #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .fill_en    (fill_en),
    .fill_idx   (fill_idx),
    .fill_dirty (fill_dirty),
    .upd_en     (step),
    .upd_idx    (cur_idx),
    .upd_inv    (cur_inv),
    .line_valid (line_valid),
    .line_dirty (line_dirty)
  );

endmodule

// File: rtl/l2m_chk.sv
module l2m_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctrl_rdata,
  input logic        launch,
  input logic        blocked_wr,
  input logic        walk_done,
  input logic        cur_wb,
  input logic        wb_req,
  input logic        wb_ack,
  input logic [31:0] wb_addr
);

  // R3
  busy_on_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> ctrl_rdata[8]);

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[8] && !walk_done) |=> ctrl_rdata[8]);

  // R4
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)));

  // R5
  wb_only_cleaning_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> cur_wb);

  // R9
  disabled_no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[0] |-> !launch);

  // R10
  blocked_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_wr |=> ctrl_rdata[12]);

  // R12
  idle_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[8] |-> !wb_req);

endmodule

bind l2m_engine l2m_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_rdata (ctrl_rdata),
  .launch     (launch),
  .blocked_wr (blocked_wr),
  .walk_done  (walk_done),
  .cur_wb     (cur_wb),
  .wb_req     (wb_req),
  .wb_ack     (wb_ack),
  .wb_addr    (wb_addr)
);

// File: tb/l2m_engine_test.sv
module l2m_engine_test;
  localparam int N = 16;
  localparam int IW = 4;

  logic clk = 1'b0, rst_n = 1'b0, cfg_lsz = 1'b0;
  logic wr_en = 1'b0, fill_en = 1'b0, fill_dirty = 1'b0, wb_ack = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [IW-1:0] fill_idx = '0;
  logic [31:0] ctrl_rdata, wb_addr;
  logic wb_req;
  logic [N-1:0] line_valid, line_dirty;

  int tests = 0, fails = 0, cycles = 0, ack_lat = 0, wcnt = 0;
  logic [31:0] seen[$];

  always #4 clk = ~clk;

  l2m_engine #(.N_LINES(N)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_lsz(cfg_lsz), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ctrl_rdata(ctrl_rdata), .fill_en(fill_en), .fill_idx(fill_idx),
    .fill_dirty(fill_dirty), .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
    .line_valid(line_valid), .line_dirty(line_dirty));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // ---------------- reference model ----------------
  bit mdis, mmode, merr, marmed, mbusy, mwb, minv;
  bit [2:0] mrop;
  bit [31:0] mend;
  bit mv[N], md[N];
  int q[$];

  function automatic int sh();
    return cfg_lsz ? 6 : 7;
  endfunction

  function automatic void start_walk(int first, int last, bit wb, bit inv);
    q.delete();
    for (int i = first; i <= last; i++) q.push_back(i);
    mwb = wb; minv = inv; mbusy = 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mdis = 0; mmode = 0; merr = 0; marmed = 0; mbusy = 0; mrop = 0; mend = 0;
      mwb = 0; minv = 0; q.delete();
      for (int i = 0; i < N; i++) begin mv[i] = 0; md[i] = 0; end
    end else begin
      bit busy_pre;
      busy_pre = mbusy;
      if (wb_req && wb_ack) seen.push_back(wb_addr);
      if (mbusy) begin
        int h;
        bit need;
        h = q[0];
        need = mwb && mv[h] && md[h];
        if (!need || wb_ack) begin
          md[h] = 0;
          if (minv) mv[h] = 0;
          void'(q.pop_front());
          if (q.size() == 0) mbusy = 0;
        end
      end
      if (fill_en && !busy_pre) begin mv[fill_idx] = 1; md[fill_idx] = fill_dirty; end
      if (wr_en) begin
        if (wr_sel == 0) begin
          mdis = wr_data[0]; mmode = wr_data[6]; mrop = wr_data[11:9];
          if (wr_data[12]) merr = 0;
        end else if (wr_sel <= 4) begin
          if (busy_pre) merr = 1;
          else if (!mdis) begin
            case (wr_sel)
              3'd2: begin mend = wr_data; marmed = 1; end
              3'd1: begin
                int s, e;
                s = int'((wr_data >> sh()) % N);
                e = int'((mend >> sh()) % N);
                if (marmed && wr_data != mend && e >= s && mrop <= 1)
                  start_walk(s, e, (mrop == 0) ? 1'b1 : mmode, mrop == 1);
                marmed = 0;
              end
              3'd3: if (wr_data[0]) start_walk(0, N-1, mmode, 1);
              3'd4: if (wr_data[0]) start_walk(0, N-1, 1, 0);
              default: ;
            endcase
          end
        end
      end
    end
  end

  // every-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] ec;
      logic [N-1:0] ev, ed;
      bit ereq;
      ec = '0;
      ec[0] = mdis; ec[6] = mmode; ec[8] = mbusy; ec[11:9] = mrop; ec[12] = merr;
      for (int i = 0; i < N; i++) begin ev[i] = mv[i]; ed[i] = md[i]; end
      ereq = mbusy && mwb && mv[q[0]] && md[q[0]];
      chk(ctrl_rdata[8] == ec[8], "R3 busy", 32'(ctrl_rdata[8]), 32'(ec[8]));
      chk(ctrl_rdata == ec, "R2 ctrl", ctrl_rdata, ec);
      chk(line_valid == ev, "R5 valid", 32'(line_valid), 32'(ev));
      chk(line_dirty == ed, "R4 dirty", 32'(line_dirty), 32'(ed));
      chk(wb_req == ereq, "R4 wb_req", 32'(wb_req), 32'(ereq));
      if (ereq) chk(wb_addr == 32'(q[0]) << sh(), "R8 wb_addr", wb_addr, 32'(q[0]) << sh());
    end
  end

  // acknowledge driver
  always @(negedge clk) begin
    if (!rst_n) begin wb_ack = 0; wcnt = 0; end
    else if (wb_ack) begin wb_ack = 0; wcnt = 0; end
    else if (wb_req) begin
      if (wcnt >= ack_lat) wb_ack = 1; else wcnt++;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic fill(input int i, input bit d);
    fill_en = 1; fill_idx = IW'(i); fill_dirty = d;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000 && ctrl_rdata[8]; k++) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ctrl_rdata == 0, "R1 ctrl", ctrl_rdata, 0);
    chk(line_valid == 0 && line_dirty == 0, "R1 lines", 32'(line_valid), 0);
    chk(!wb_req, "R1 wb_req", 32'(wb_req), 0);

    // R2 control readback
    wr(0, 32'hFFFF_FFFF);
    chk(ctrl_rdata == 32'h0000_0E41, "R2 readback", ctrl_rdata, 32'h0000_0E41);
    wr(0, 0);

    // R4 whole flush, R11 fill, R8 128-byte addresses
    fill(1, 1); fill(2, 0); fill(5, 1); fill(9, 1);
    chk(line_valid == 16'h0226 && line_dirty == 16'h0222, "R11 fill", 32'(line_dirty), 32'h0222);
    seen.delete(); ack_lat = 2;
    wr(4, 1);
    chk(ctrl_rdata[8], "R3 busy after trigger", 32'(ctrl_rdata[8]), 1);
    fill(0, 1); // R11: ignored while busy
    chk(!line_valid[0], "R11 fill while busy", 32'(line_valid[0]), 0);
    wait_idle();
    chk(line_dirty == 0 && line_valid == 16'h0226, "R4 flush result", 32'(line_valid), 32'h0226);
    chk(seen.size() == 3, "R4 wb count", seen.size(), 3);
    if (seen.size() == 3) begin
      chk(seen[0] == 32'h080, "R8 wb order 0", seen[0], 32'h080);
      chk(seen[1] == 32'h280, "R4 wb order 1", seen[1], 32'h280);
      chk(seen[2] == 32'h480, "R4 wb order 2", seen[2], 32'h480);
    end

    // R5 invalidate mode 0, R12 duration
    fill(3, 1); seen.delete(); ack_lat = 0;
    wr(0, 0);
    wr(3, 1);
    n = 0;
    while (ctrl_rdata[8] && n < 1000) begin n++; @(negedge clk); end
    chk(n == N, "R12 busy cycles", n, N);
    chk(line_valid == 0 && seen.size() == 0, "R5 inv no wb", 32'(seen.size()), 0);

    // R5 invalidate mode 1
    fill(4, 1); fill(6, 0); fill(12, 1); seen.delete();
    wr(0, 32'h40);
    wr(3, 1);
    wait_idle();
    chk(line_valid == 0 && seen.size() == 2, "R5 flush-inv", 32'(seen.size()), 2);

    // R6/R7 region flush, 128-byte lines: lines 2..7
    for (int i = 0; i < N; i++) fill(i, 1);
    seen.delete(); ack_lat = 1;
    wr(0, 32'h0000_0000);
    wr(2, 32'h0000_0385);
    wr(1, 32'h0000_0103);
    chk(ctrl_rdata[8], "R6 region launch", 32'(ctrl_rdata[8]), 1);
    wait_idle();
    chk(line_dirty == 16'hFF03 && line_valid == 16'hFFFF, "R6 region flush", 32'(line_dirty), 32'hFF03);
    chk(seen.size() == 6, "R7 flush wb count", seen.size(), 6);

    // R7 code 001 mode 0: lines 10..11 invalidated without writeback
    seen.delete();
    wr(0, 32'h0000_0200);
    wr(2, 32'h0000_0590);
    wr(1, 32'h0000_0500);
    wait_idle();
    chk(line_valid == 16'hF3FF && seen.size() == 0, "R7 region inv", 32'(line_valid), 32'hF3FF);

    // R6 start without arm
    wr(1, 32'h0000_0000);
    chk(!ctrl_rdata[8], "R6 unarmed start", 32'(ctrl_rdata[8]), 0);
    // R6 end equal to start
    wr(2, 32'h0000_0100); wr(1, 32'h0000_0100);
    chk(!ctrl_rdata[8], "R6 equal start/end", 32'(ctrl_rdata[8]), 0);
    // R6 end index below start index
    wr(2, 32'h0000_0100); wr(1, 32'h0000_0300);
    chk(!ctrl_rdata[8], "R6 reversed region", 32'(ctrl_rdata[8]), 0);
    // R7 reserved code
    wr(0, 32'h0000_0400);
    wr(2, 32'h0000_0300); wr(1, 32'h0000_0000);
    chk(!ctrl_rdata[8] && line_valid == 16'hF3FF, "R7 reserved code", 32'(ctrl_rdata[8]), 0);

    // R9 disabled
    wr(0, 32'h0000_0001);
    wr(4, 1);
    chk(!ctrl_rdata[8] && line_dirty == 16'hF303, "R9 disabled flush", 32'(line_dirty), 32'hF303);
    wr(2, 32'h0000_0300); wr(0, 0); wr(1, 32'h0000_0000);
    chk(!ctrl_rdata[8], "R9 no arm when disabled", 32'(ctrl_rdata[8]), 0);

    // R10 busy write ignored, error sticky
    ack_lat = 3;
    wr(4, 1);
    wr(2, 32'h0000_0300);
    chk(ctrl_rdata[12], "R10 error set", 32'(ctrl_rdata[12]), 1);
    wait_idle();
    wr(1, 32'h0000_0000);
    chk(!ctrl_rdata[8], "R10 end write ignored", 32'(ctrl_rdata[8]), 0);
    wr(0, 32'h0000_1000);
    chk(!ctrl_rdata[12], "R10 error cleared", 32'(ctrl_rdata[12]), 0);

    // R8 64-byte lines: region inside line 3
    cfg_lsz = 1;
    fill(3, 1); seen.delete(); ack_lat = 0;
    wr(0, 0);
    wr(2, 32'h0000_00FF); wr(1, 32'h0000_00C0);
    wait_idle();
    chk(seen.size() == 1 && seen[0] == 32'h0C0, "R8 64-byte wb", seen.size() ? seen[0] : 0, 32'h0C0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule